// File: doc/BRIEF.md
# Double-Buffered Variable-Interval Timer

This block is a 32-bit down-counting timer that produces an unbroken chain of intervals whose lengths may differ from one interval to the next. Software stages the length of the next interval in a staging register while the current interval is still counting. When the count reaches zero, the timer takes the staged value into the counter on that same clock edge and raises a pending interrupt flag. The next interval therefore starts without waiting for software, and the delay before the interrupt handler runs never shifts the timebase.

The expected use is a handler that clears the flag, works out the following interval and writes it into the staging register before the running interval ends. If software writes nothing, the timer keeps reusing the last staged value, which gives a fixed-period timer. A small write port with a combinational read port gives access to the staging value, the enable bit, a status word and the live count. A level interrupt output follows the pending flag.

The controller has two states. ST_IDLE holds the counter still and moves to ST_RUN on the first edge at which the enable bit is set. That same edge loads the staged value. ST_RUN counts down and reloads at zero. It stays in ST_RUN while the enable bit is set and returns to ST_IDLE when the enable bit is clear.

Top module: `reload_timer`

## Requirements
- R1: After reset, every readable location (staging 0, control 1, status 2, count 3) reads zero, the controller is in ST_IDLE, and `irq` is low.
- R2: Writing 1 to bit 0 of address 1 while idle loads the staging value into the counter on the next clock edge. Status bit 1 (consumed) then reads 1.
- R3: While running and enabled, the count falls by exactly one on each clock edge until it reaches zero.
- R4: A write to the staging register (address 0) while running does not change the count in progress. The new value is used only at the next expiry.
- R5: On the edge at which a zero count is seen while running, the counter takes the staging value. There is no idle cycle, so a staged value N gives an interval of exactly N+1 cycles, and consumed reads 1 afterwards.
- R6: If the staging register is not written again, every later interval has the same length (periodic operation).
- R7: Each expiry sets the pending flag (status bit 0), and `irq` equals that flag. Writing status (address 2) with bit 0 set clears it, and writing it with bit 0 clear has no effect.
- R8: An expiry while the flag is already set increments the overrun count in status bits 15:8, which saturates at 255. An expiry wins over a clear in the same cycle.
- R9: Clearing the enable bit freezes the count and stops new expiries. Enabling again from idle reloads the counter from the staging register.
- R10: A staging write clears consumed, even when a transfer happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 staging, 1 control, 2 status clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (0 staging, 1 control, 2 status, 3 count) |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt request, equal to the pending flag |

## Verification
The main stimulus is a chain of about forty intervals with random lengths. A handler in the bench clears the flag and stages the next length while each interval runs. Measuring the time of every expiry edge against the running sum of N+1 values separates exact reload timing from an off-by-one or a lost-cycle gap, and an error of this kind would show as growing drift. Directed patterns cover the rest: a huge staged value that is overwritten before expiry shows whether a mid-interval write leaks into the count, and repeated expiries with no new write confirm periodic reuse. A zero-length interval left unserviced drives the overrun counter to saturation and also tests set-over-clear priority. Disable and re-enable sequences check freezing and reloading.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    localparam logic [1:0] ADDR_HOLD = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    localparam int STAT_PEND_BIT = 0;
    localparam int STAT_CONS_BIT = 1;
    localparam int STAT_OVR_LSB  = 8;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] hold_q,
    output logic             en_q,
    output logic             hold_wr,
    output logic             clr_req
);
    // Decoded write strobes
    always_comb begin
        hold_wr = wr_en && (wr_addr == ADDR_HOLD);
        clr_req = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (hold_wr) begin
                hold_q <= wr_data;
            end
            if (wr_en && (wr_addr == ADDR_CTRL)) begin
                en_q <= wr_data[0];
            end
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hold,
    output logic [CNT_W-1:0] count_q,
    output logic             running,
    output logic             load,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode: load on entry, expire on zero while counting
    always_comb begin
        load    = 1'b0;
        expire  = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: load = en;
            ST_RUN: begin
                running = 1'b1;
                expire  = en && (count_q == '0);
            end
            default: ;
        endcase
    end

    // Counter: reload shares the edge with terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load || expire) begin
            count_q <= hold;
        end else if (running && en) begin
            count_q <= count_q - ONE;
        end
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             expire,
    input  logic             hold_wr,
    input  logic             clr_req,
    output logic             pending_q,
    output logic             consumed_q,
    output logic [OVR_W-1:0] ovr_q
);
    localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            consumed_q <= 1'b0;
            ovr_q      <= '0;
        end else begin
            // Expiry has priority over a clear request
            if (expire) begin
                pending_q <= 1'b1;
            end else if (clr_req) begin
                pending_q <= 1'b0;
            end
            if (expire && pending_q && (ovr_q != OVR_MAX)) begin
                ovr_q <= ovr_q + OVR_W'(1);
            end
            // A fresh staging write always leaves the value unconsumed
            if (hold_wr) begin
                consumed_q <= 1'b0;
            end else if (load || expire) begin
                consumed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic [CNT_W-1:0] hold_q;
    logic             en_q;
    logic             hold_wr;
    logic             clr_req;
    logic [CNT_W-1:0] count_q;
    logic             running;
    logic             load;
    logic             expire;
    logic             pending_q;
    logic             consumed_q;
    logic [OVR_W-1:0] ovr_q;
    logic [CNT_W-1:0] stat_word;
    logic [CNT_W-1:0] ctrl_word;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hold_q  (hold_q),
        .en_q    (en_q),
        .hold_wr (hold_wr),
        .clr_req (clr_req)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .hold    (hold_q),
        .count_q (count_q),
        .running (running),
        .load    (load),
        .expire  (expire)
    );

    tmr_flags #(.OVR_W(OVR_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .expire     (expire),
        .hold_wr    (hold_wr),
        .clr_req    (clr_req),
        .pending_q  (pending_q),
        .consumed_q (consumed_q),
        .ovr_q      (ovr_q)
    );

    always_comb begin
        stat_word = '0;
        stat_word[STAT_PEND_BIT] = pending_q;
        stat_word[STAT_CONS_BIT] = consumed_q;
        stat_word[STAT_OVR_LSB +: OVR_W] = ovr_q;
        ctrl_word = '0;
        ctrl_word[0] = en_q;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_HOLD: rd_data = hold_q;
            ADDR_CTRL: rd_data = ctrl_word;
            ADDR_STAT: rd_data = stat_word;
            ADDR_CNT:  rd_data = count_q;
            default:   rd_data = '0;
        endcase
    end

    assign irq = pending_q;
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
    parameter int CNT_W = 32,
    parameter int OVR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] hold,
    input logic             pending,
    input logic             consumed,
    input logic [OVR_W-1:0] ovr,
    input logic             hold_wr
);
    localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    a_r5_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count == '0) |=> (count == $past(hold)));

    a_r7_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count == '0) |=> pending);

    a_r8_overrun_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count == '0 && pending && ovr != OVR_MAX) |=> (ovr == $past(ovr) + OVR_W'(1)));

    a_r8_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(running && en && count == '0)) |=> $stable(ovr));

    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(count));

    a_r9_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pending) |=> !pending);

    a_r10_write_unconsumes: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !consumed);
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W), .OVR_W(OVR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .running  (running),
    .count    (count_q),
    .hold     (hold_q),
    .pending  (pending_q),
    .consumed (consumed_q),
    .ovr      (ovr_q),
    .hold_wr  (hold_wr)
);

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
    localparam int CW = 32;
    localparam int NCHAIN = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = 2'd0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    bit done = 1'b0;

    reload_timer u_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint span_of(input longint n);
        return n + 1;
    endfunction

    function automatic logic [CW-1:0] stat_of(input logic pend, input logic cons, input int ovr);
        logic [CW-1:0] w;
        w = '0;
        w[0] = pend;
        w[1] = cons;
        w[15:8] = ovr[7:0];
        return w;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [CW-1:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic wait_irq();
        while (irq !== 1'b1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        logic [CW-1:0] v;
        logic [CW-1:0] c;
        longint lens[NCHAIN+1];
        longint t_prev, t_now, t_first, t_load, total;
        int unsigned seed;
        seed = $urandom(32'd7321);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[1:0], v);
            chk("R1 read zero", v, 0);
        end
        chk("R1 irq low", irq, 0);

        // Drift chain with a bench-side handler
        lens[0] = 10;
        for (int k = 1; k <= NCHAIN; k++) lens[k] = 8 + $urandom_range(0, 60);
        bus_wr(2'd0, CW'(lens[0]));
        bus_wr(2'd1, 1);
        t_load = cyc + 1;
        bus_wr(2'd0, CW'(lens[1]));
        wait_irq();
        t_first = cyc;
        t_prev = cyc;
        chk("R5 first interval", t_first - t_load, span_of(lens[0]));
        total = 0;
        for (int k = 1; k < NCHAIN; k++) begin
            bus_wr(2'd2, 1);
            bus_wr(2'd0, CW'(lens[k+1]));
            wait_irq();
            t_now = cyc;
            chk("R5 chained interval", t_now - t_prev, span_of(lens[k]));
            total += span_of(lens[k]);
            t_prev = t_now;
        end
        chk("R5 zero drift total", t_prev - t_first, total);
        bus_wr(2'd2, 1);
        bus_rd(2'd2, v);
        chk("R8 no overrun when serviced", v[15:8], 0);
        bus_wr(2'd1, 0);
        @(negedge clk);

        // R2/R3/R4: load, decrement, mid-interval write
        bus_wr(2'd0, 30);
        bus_wr(2'd1, 1);
        @(negedge clk);
        bus_rd(2'd3, v);
        chk("R2 load on enable", v, 30);
        bus_rd(2'd2, v);
        chk("R2 consumed set", v[1], 1);
        @(negedge clk);
        bus_rd(2'd3, v);
        chk("R3 decrement", v, 29);
        repeat (4) @(negedge clk);
        bus_rd(2'd3, c);
        bus_wr(2'd0, 32'hFFFF_0000);
        bus_rd(2'd3, v);
        chk("R4 count undisturbed", v, c - 1);
        bus_rd(2'd2, v);
        chk("R10 consumed cleared", v[1], 0);
        bus_wr(2'd0, 12);
        wait_irq();
        bus_rd(2'd3, v);
        chk("R5 reload value", v, 12);
        bus_rd(2'd2, v);
        chk("R5 consumed after reload", v, stat_of(1'b1, 1'b1, 0));

        // R7: write of zero has no effect, one clears
        bus_wr(2'd2, 0);
        chk("R7 zero write ignored", irq, 1);
        bus_wr(2'd2, 1);
        chk("R7 clear", irq, 0);
        t_prev = cyc - 2;

        // R6: periodic reuse of staged value
        for (int p = 0; p < 3; p++) begin
            wait_irq();
            t_now = cyc;
            if (p > 0) chk("R6 periodic interval", t_now - t_prev, 13);
            t_prev = t_now;
            bus_wr(2'd2, 1);
        end

        // R9: disable freezes, re-enable reloads
        bus_wr(2'd1, 0);
        bus_rd(2'd3, c);
        repeat (20) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R9 count frozen", v, c);
        chk("R9 no new irq", irq, 0);
        bus_wr(2'd0, 5);
        bus_wr(2'd1, 1);
        @(negedge clk);
        bus_rd(2'd3, v);
        chk("R9 reload on re-enable", v, 5);

        // R8: overrun saturation and set-over-clear
        bus_wr(2'd0, 0);
        repeat (320) @(negedge clk);
        bus_rd(2'd2, v);
        chk("R8 overrun saturates", v[15:8], 255);
        bus_wr(2'd2, 1);
        chk("R8 expiry beats clear", irq, 1);
        bus_wr(2'd1, 0);
        bus_wr(2'd2, 1);
        chk("R7 clear after stop", irq, 0);

        done = 1'b1;
        finish_run();
    end
endmodule